// File: doc/BRIEF.md
# Relocatable Instruction Cache

This block holds 512 bytes of coprocessor code in a window that slides over the 16-bit program address space. The window starts at a programmable cache base. A fetch whose distance from that base, taken modulo 2^16, is below 512 falls inside the window. The storage is 32 lines of 16 bytes, and each line has one valid flag. No address tags are stored. The position of a byte in the window fixes the cache slot it occupies.

A fetch to a valid line is answered from the local storage in one cycle. A fetch to an invalid line first reads all 16 bytes of that line from the backing bus, in ascending order, and then answers. A fetch outside the window becomes a single bus read and leaves the cache unchanged. A host port reads and writes the storage relative to the cache base. Writing the last byte of a line marks that line valid, so software can preload code. A flush input drops every valid flag. Reset drops the flags and zeroes the storage.

Top module: `icache_window`

## Requirements
- R1: A fetch with offset = (fetch_addr - cache_base) mod 2^16 below 512 whose line (offset bits 8:4) is valid is acknowledged one cycle after it is accepted. It returns the byte at storage index offset[8:0] and causes no bus beat.
- R2: A fetch inside the window to an invalid line makes exactly 16 bus beats. Beat n (n = 0..15) is at address {bank, ((cache_base + (offset & 0xFFF0)) & 0xFFF0) + n}, and its byte goes to storage index (offset & 0x1F0) + n. The line is then valid and the fetch is acknowledged with the byte at offset[8:0]. fetch_ack stays low during the fill.
- R3: A fetch with offset of 512 or more makes one bus beat at {bank, fetch_addr} and returns that byte. It changes no storage and no valid flag, so repeating it makes another beat.
- R4: The offset wraps modulo 2^16. With cache_base 0xFF00, fetch 0x0080 is in the window at offset 0x180, and fetch 0xFEFF is outside it.
- R5: A one-cycle pulse on flush clears all 32 valid flags. The next fetch to any previously valid line refills it. Flush wins over a valid-set in the same cycle.
- R6: After reset every valid flag is clear, every storage byte is zero, and fetch_ack, bus_req and mmio_busy are low.
- R7: mmio_rdata combinationally shows the storage byte at index (mmio_addr + cache_base[8:0]) mod 512.
- R8: With mmio_we high and mmio_busy low, the storage byte at that same index takes mmio_wdata at the clock edge. When the index has low four bits equal to 15, the line holding it becomes valid. A write to any other byte position leaves the valid flags unchanged.
- R9: mmio_busy is high exactly while a line fill is in progress. A host write presented while it is high is ignored.
- R10: The fetcher holds fetch_req high and fetch_addr stable until fetch_ack. fetch_ack is a one-cycle pulse, and no new request is accepted in the ack cycle.
- R11: bus_req stays high with a stable bus_addr until a cycle with bus_ready high. That edge is one beat, with bus_rdata valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_base | input | 16 | Start address of the cached window |
| bank | input | 8 | Upper bus address bits for every bus access |
| flush | input | 1 | Clear all valid flags |
| fetch_req | input | 1 | Fetch request, held until acknowledged |
| fetch_addr | input | 16 | Program address of the fetch |
| fetch_ack | output | 1 | One-cycle fetch completion pulse |
| fetch_data | output | 8 | Fetched byte, valid with fetch_ack |
| bus_req | output | 1 | Bus read request |
| bus_addr | output | 24 | Bus byte address |
| bus_ready | input | 1 | Bus beat completes this cycle |
| bus_rdata | input | 8 | Bus read data, valid with bus_ready |
| mmio_addr | input | 9 | Host address, relative to the cache base |
| mmio_we | input | 1 | Host write strobe |
| mmio_wdata | input | 8 | Host write data |
| mmio_rdata | output | 8 | Host read data |
| mmio_busy | output | 1 | Line fill in progress; host writes ignored |

## Verification
A wrong valid flag shows at the ports on the next fetch into that line. A stale flag gives a one-cycle answer with no bus beats where 16 beats were due. A lost flag gives a refill where the answer should have come at once. Both show as a wrong beat count within about 20 cycles of the request. A wrong fill counter or line base shows as a wrong bus address on the very beat it drives. A wrong storage write shows as a wrong fetch_data byte or a wrong mmio_rdata byte as soon as that byte is read back, and host reads make any slot visible in the same cycle.

// File: rtl/icw_pkg.sv
package icw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_BYPASS = 2'd2
    } icw_state_e;
endpackage

// File: rtl/icw_store.sv
module icw_store #(
    parameter int DATA_W = 8,
    parameter int IX_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IX_W-1:0]   wr_ix,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IX_W-1:0]   rd_a_ix,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IX_W-1:0]   rd_b_ix,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int DEPTH = 1 << IX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_ix] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_a_data = mem_q[rd_a_ix];
    assign rd_b_data = mem_q[rd_b_ix];
endmodule

// File: rtl/icw_valid.sv
module icw_valid #(
    parameter int LINES = 32,
    parameter int LN_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_fill,
    input  logic [LN_W-1:0]  fill_line,
    input  logic             set_host,
    input  logic [LN_W-1:0]  host_line,
    output logic [LINES-1:0] valid_q
);
    logic [LINES-1:0] valid_d;

    always_comb begin
        valid_d = valid_q;
        if (set_fill) valid_d[fill_line] = 1'b1;
        if (set_host) valid_d[host_line] = 1'b1;
        if (flush)    valid_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)) else $error("flush left a valid flag"); // R5
    AST_FILL_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fill && !flush) |=> valid_q[$past(fill_line)]) else $error("fill did not mark line"); // R2
endmodule

// File: rtl/icw_ctrl.sv
module icw_ctrl
    import icw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LINE_W = 4,
    parameter int LN_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fetch_req,
    input  logic [ADDR_W-1:0]        fetch_addr,
    input  logic [ADDR_W-1:0]        cache_base,
    input  logic [ADDR_W-LINE_W-1:0] off_line,
    input  logic                     in_win,
    input  logic                     line_valid,
    input  logic [DATA_W-1:0]        hit_byte,
    output logic                     fetch_ack,
    output logic [DATA_W-1:0]        fetch_data,
    output logic                     bus_req,
    output logic [ADDR_W-1:0]        bus_low_addr,
    input  logic                     bus_ready,
    input  logic [DATA_W-1:0]        bus_rdata,
    output logic                     fill_we,
    output logic [LN_W+LINE_W-1:0]   fill_ix,
    output logic                     fill_done,
    output logic [LN_W-1:0]          fill_line,
    output logic                     busy
);
    localparam int HI_W = ADDR_W - LINE_W;

    typedef struct packed {
        icw_state_e        st;
        logic [LINE_W-1:0] cnt;
        logic [LN_W-1:0]   line;
        logic [HI_W-1:0]   bus_hi;
        logic [ADDR_W-1:0] byp;
        logic              ack;
        logic [DATA_W-1:0] data;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic [ADDR_W-1:0] line_sum;

    assign line_sum = cache_base + {off_line, {LINE_W{1'b0}}};

    always_comb begin
        r_d       = r_q;
        r_d.ack   = 1'b0;
        fill_we   = 1'b0;
        fill_done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (fetch_req && !r_q.ack) begin
                    if (in_win && line_valid) begin
                        r_d.ack  = 1'b1;
                        r_d.data = hit_byte;
                    end else if (in_win) begin
                        r_d.st     = ST_FILL;
                        r_d.cnt    = '0;
                        r_d.line   = off_line[LN_W-1:0];
                        r_d.bus_hi = line_sum[ADDR_W-1:LINE_W];
                    end else begin
                        r_d.st  = ST_BYPASS;
                        r_d.byp = fetch_addr;
                    end
                end
            end
            ST_FILL: begin
                if (bus_ready) begin
                    fill_we = 1'b1;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (&r_q.cnt) begin
                        fill_done = 1'b1;
                        r_d.st    = ST_IDLE;
                    end
                end
            end
            ST_BYPASS: begin
                if (bus_ready) begin
                    r_d.ack  = 1'b1;
                    r_d.data = bus_rdata;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign busy         = (r_q.st == ST_FILL);
    assign bus_req      = (r_q.st != ST_IDLE);
    assign bus_low_addr = busy ? {r_q.bus_hi, r_q.cnt} : r_q.byp;
    assign fill_ix      = {r_q.line, r_q.cnt};
    assign fill_line    = r_q.line;
    assign fetch_ack    = r_q.ack;
    assign fetch_data   = r_q.data;

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ack |=> !fetch_ack) else $error("ack longer than one cycle"); // R10
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_low_addr))) else $error("bus request dropped"); // R11
    AST_NO_ACK_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !fetch_ack) else $error("ack during fill"); // R2
endmodule

// File: rtl/icache_window.sv
module icache_window #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8,
    parameter int DATA_W = 8,
    parameter int LINE_W = 4,
    parameter int LN_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        cache_base,
    input  logic [BANK_W-1:0]        bank,
    input  logic                     flush,
    input  logic                     fetch_req,
    input  logic [ADDR_W-1:0]        fetch_addr,
    output logic                     fetch_ack,
    output logic [DATA_W-1:0]        fetch_data,
    output logic                     bus_req,
    output logic [BANK_W+ADDR_W-1:0] bus_addr,
    input  logic                     bus_ready,
    input  logic [DATA_W-1:0]        bus_rdata,
    input  logic [LN_W+LINE_W-1:0]   mmio_addr,
    input  logic                     mmio_we,
    input  logic [DATA_W-1:0]        mmio_wdata,
    output logic [DATA_W-1:0]        mmio_rdata,
    output logic                     mmio_busy
);
    localparam int IX_W  = LN_W + LINE_W;
    localparam int LINES = 1 << LN_W;

    logic [ADDR_W-1:0] offset;
    logic              in_win;
    logic [LINES-1:0]  valid_q;
    logic [DATA_W-1:0] hit_byte;
    logic [ADDR_W-1:0] bus_low;
    logic              fill_we, fill_done;
    logic [IX_W-1:0]   fill_ix, host_ix, wr_ix;
    logic [LN_W-1:0]   fill_line;
    logic              host_ok, wr_en;
    logic [DATA_W-1:0] wr_data;

    assign offset  = fetch_addr - cache_base;
    assign in_win  = (offset[ADDR_W-1:IX_W] == '0);
    assign host_ix = mmio_addr + cache_base[IX_W-1:0];
    assign host_ok = mmio_we && !mmio_busy;
    assign wr_en   = fill_we || host_ok;
    assign wr_ix   = fill_we ? fill_ix : host_ix;
    assign wr_data = fill_we ? bus_rdata : mmio_wdata;
    assign bus_addr = {bank, bus_low};

    icw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W), .LN_W(LN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .cache_base(cache_base),
        .off_line(offset[ADDR_W-1:LINE_W]), .in_win(in_win),
        .line_valid(valid_q[offset[IX_W-1:LINE_W]]), .hit_byte(hit_byte),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .bus_req(bus_req), .bus_low_addr(bus_low), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .fill_we(fill_we), .fill_ix(fill_ix), .fill_done(fill_done), .fill_line(fill_line),
        .busy(mmio_busy)
    );

    icw_valid #(.LINES(LINES), .LN_W(LN_W)) u_valid (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .set_fill(fill_done), .fill_line(fill_line),
        .set_host(host_ok && (&host_ix[LINE_W-1:0])), .host_line(host_ix[IX_W-1:LINE_W]),
        .valid_q(valid_q)
    );

    icw_store #(.DATA_W(DATA_W), .IX_W(IX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_ix(wr_ix), .wr_data(wr_data),
        .rd_a_ix(offset[IX_W-1:0]), .rd_a_data(hit_byte),
        .rd_b_ix(host_ix), .rd_b_data(mmio_rdata)
    );

    AST_BUSY_HAS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        mmio_busy |-> bus_req) else $error("busy without bus request"); // R9
endmodule

// File: tb/tb_icache_window.sv
module tb_icache_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cache_base = '0;
    logic [7:0]  bank = '0;
    logic        flush = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_ack;
    logic [7:0]  fetch_data;
    logic        bus_req;
    logic [23:0] bus_addr;
    logic        bus_ready = 1'b0;
    logic [7:0]  bus_rdata;
    logic [8:0]  mmio_addr = '0;
    logic        mmio_we = 1'b0;
    logic [7:0]  mmio_wdata = '0;
    logic [7:0]  mmio_rdata;
    logic        mmio_busy;

    int vectors = 0, miscompares = 0, beats = 0, rcnt = 0;
    bit throttle = 1'b0;
    logic [7:0]  mmem [512];
    bit          mvalid [32];
    logic [23:0] exp_q [$];

    always #5 clk = ~clk;

    icache_window dut (.*);

    function automatic logic [7:0] busval(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
    endfunction
    assign bus_rdata = busval(bus_addr);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus model and per-clock beat comparison
    always @(negedge clk) begin
        if (rst_n) begin
            rcnt++;
            bus_ready = throttle ? (rcnt % 3 != 0) : 1'b1;
            if (bus_req && bus_ready) begin
                logic [23:0] e;
                beats++;
                if (exp_q.size() == 0) chk(0, "R11 unexpected beat", bus_addr, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(bus_addr == e, "R2/R3 beat address", bus_addr, e);
                end
            end
        end
    end

    task automatic fetch(input logic [15:0] a, input string tag);
        logic [15:0] off = a - cache_base;
        logic [7:0]  expd;
        int nexp = 0, b0, lat = 0;
        bit hit = 1'b0;
        if (off < 512 && mvalid[off[8:4]]) begin
            hit = 1'b1;
            expd = mmem[off[8:0]];
        end else if (off < 512) begin
            logic [15:0] lb = (cache_base + (off & 16'hFFF0)) & 16'hFFF0;
            for (int n = 0; n < 16; n++) begin
                exp_q.push_back({bank, lb + 16'(n)});
                mmem[{off[8:4], 4'(n)}] = busval({bank, lb + 16'(n)});
            end
            mvalid[off[8:4]] = 1'b1;
            nexp = 16;
            expd = mmem[off[8:0]];
        end else begin
            exp_q.push_back({bank, a});
            nexp = 1;
            expd = busval({bank, a});
        end
        b0 = beats;
        @(negedge clk);
        fetch_req = 1'b1;
        fetch_addr = a;
        do begin
            @(negedge clk);
            lat++;
        end while (!fetch_ack && lat < 400);
        fetch_req = 1'b0;
        chk(fetch_ack && fetch_data == expd, {tag, " fetch data"}, fetch_data, expd);
        chk(beats - b0 == nexp, {tag, " beat count"}, beats - b0, nexp);
        if (hit) chk(lat == 1, "R1 hit latency", lat, 1);
        @(negedge clk);
        chk(!fetch_ack, "R10 ack pulse", fetch_ack, 0);
    endtask

    task automatic host_wr(input logic [8:0] a, input logic [7:0] d);
        logic [8:0] ix = a + cache_base[8:0];
        @(negedge clk);
        mmio_we = 1'b1;
        mmio_addr = a;
        mmio_wdata = d;
        @(negedge clk);
        mmio_we = 1'b0;
        mmem[ix] = d;
        if (ix[3:0] == 4'hF) mvalid[ix[8:4]] = 1'b1;
    endtask

    task automatic host_rd(input logic [8:0] a, input string tag);
        logic [8:0] ix = a + cache_base[8:0];
        @(negedge clk);
        mmio_addr = a;
        #1;
        chk(mmio_rdata == mmem[ix], tag, mmio_rdata, mmem[ix]);
    endtask

    initial begin
        #2_000_000;
        chk(0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mmem[i] = '0;
        for (int i = 0; i < 32; i++) mvalid[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R6 reset state
        chk(!fetch_ack && !bus_req && !mmio_busy, "R6 idle outputs", {fetch_ack, bus_req, mmio_busy}, 0);
        host_rd(9'h000, "R6 zero byte");
        host_rd(9'h1FF, "R6 zero byte");
        host_rd(9'h0A5, "R6 zero byte");

        cache_base = 16'h1000; bank = 8'h03;
        fetch(16'h1005, "R2 miss fill");
        fetch(16'h1005, "R1 hit");
        fetch(16'h100F, "R1 hit end of line");
        fetch(16'h1010, "R2 next line fill");
        fetch(16'h1200, "R3 bypass");
        fetch(16'h1200, "R3 bypass not cached");
        throttle = 1'b1;
        fetch(16'h11F3, "R11 throttled fill");
        fetch(16'h11F0, "R1 hit after throttled fill");
        host_rd(9'h1F3, "R7 host read");
        throttle = 1'b0;

        cache_base = 16'hFF00; bank = 8'hA1;
        fetch(16'h0080, "R4 wrap fill");
        fetch(16'hFEFF, "R4 below base bypass");
        host_rd(9'h180, "R7 host read wrapped");

        // R8 preload line 20 via host, last byte sets valid
        host_wr(9'h060, 8'h77);
        for (int k = 0; k < 16; k++) host_wr(9'h040 + 9'(k), 8'hC0 + 8'(k));
        fetch(16'h0047, "R8 preloaded hit");
        fetch(16'h0060, "R8 non-last write no valid");
        host_rd(9'h04F, "R8 host write visible");

        // R9 host write during fill is ignored
        fork
            fetch(16'h00A4, "R9 fill");
            begin
                repeat (3) @(negedge clk);
                chk(mmio_busy, "R9 busy during fill", mmio_busy, 1);
                mmio_we = 1'b1; mmio_addr = 9'h048; mmio_wdata = 8'hEE;
                @(negedge clk);
                mmio_we = 1'b0;
            end
        join
        chk(!mmio_busy, "R9 busy released", mmio_busy, 0);
        host_rd(9'h048, "R9 write ignored");

        // R5 flush
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int i = 0; i < 32; i++) mvalid[i] = 1'b0;
        fetch(16'h0047, "R5 refill after flush");
        fetch(16'h0080, "R5 refill after flush");
        fetch(16'h0081, "R1 hit after refill");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule